// File: doc/BRIEF.md
# Abstract Register Command Sequencer

This block takes one debug "access register" command and turns it into a short program of 32-bit RISC-V instruction words. It writes the words one at a time into a small instruction buffer that a halted hart later runs. The command names a register number, a transfer flag, a write flag, an access size and a post-execute flag. Control registers, integer registers and floating-point registers each get their own access pattern. Any floating-point register, and the three floating-point control CSRs, is wrapped in extra code. That code saves s0 and `mstatus`, turns on the floating-point status field, and restores both afterwards, so the debugger can reach these registers even while the FPU is switched off.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The command fields, `csr_access_en` and `err_in` are sampled on that same edge. While a command is in flight, `cmd_ready` stays low, so a source that holds `cmd_valid` is held off until `done` has pulsed. The buffer write side is a plain strobe with no back-pressure: one word per cycle, at rising indices starting from 0. Moving data between the debug data register and the transfer CSR is handled outside this block.

Top module: `abs_reg_seq`

## Requirements
- R1: After reset `cmd_ready` is 1. It drops on the cycle after a command is accepted and stays 0 until the cycle after `done`, when it returns to 1.
- R2: An accepted command produces a burst of `buf_we` on back-to-back cycles, with `buf_idx` counting 0, 1, 2 and so on. The burst starts on the cycle after acceptance. `done` pulses for one cycle, on the cycle after the last write, with `buf_we` low.
- R3: If `err_in` is non-zero at acceptance, there is no buffer write and `err_set` stays 0. `done` pulses on the cycle after acceptance.
- R4: The following register numbers are floating-point registers: 0x1020–0x103F, 0x001, 0x002 and 0x003. Such a register gets a prologue of five words, in this order, with s0 = x8:
  - `csrrw x0,0x7B2,s0`
  - `csrrs s0,0x300,x0`
  - `csrrw x0,0x7B3,s0`
  - `lui s0,FS_HI` (20'h00006 by default, the FS mask shifted right by 12)
  - `csrrs x0,0x300,s0`
- R5: A floating-point register gets an epilogue of three words after its access, in this order:
  - `csrrs s0,0x7B3,x0`
  - `csrrw x0,0x300,s0`
  - `csrrs s0,0x7B2,x0`
- R6: A register number below 0x1000 with `csr_access_en`=1 takes the CSR path. A CSR that is not a floating-point CSR is bracketed by a single `csrrw x0,0x7B2,s0` before its access and a single `csrrs s0,0x7B2,x0` after it. A floating-point CSR gets no bracket beyond the R4 prologue and the R5 epilogue.
- R7: Register numbers 0x1000–0x101F take the integer-register path with xN = regno − 0x1000. A read emits `csrrw x0,XFER,xN` and a write emits `csrrs xN,XFER,x0`, where XFER is 0x7C0 by default.
- R8: Floating-point data registers (0x1020–0x103F) use fN = regno − 0x1020.
  - A read emits `fmv.x.w s0,fN` then `csrrw x0,XFER,s0`.
  - A write emits `csrrs s0,XFER,x0` then `fmv.w.x fN,s0`.
- R9: A CSR read emits `csrrs s0,csr,x0` then `csrrw x0,XFER,s0`. A CSR write emits `csrrs s0,XFER,x0` then `csrrw x0,csr,s0`.
- R10: A transfer command is not supported in any of these cases:
  - the size field is anything other than 2 (32 bits);
  - the register number is 0x1040 or above;
  - the register number is below 0x1000 while `csr_access_en`=0.
  
  An unsupported command writes no word and pulses `done` together with `err_set`=1 and `err_code`=2. Outside that pulse, `err_code` is 0.
- R11: The last word written is the terminator. It is EBREAK (0x00100073) when postexec is clear. When postexec is set it is `jal x0` with byte offset PBUF_GAP − 4·index, where PBUF_GAP is 64 by default.
- R12: With the transfer flag clear, the only word written is the terminator, at index 0. The register number and size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_regno | input | 16 | Register number |
| cmd_transfer | input | 1 | Perform the register transfer |
| cmd_write | input | 1 | 1 = write the register, 0 = read it |
| cmd_size | input | 3 | Access size code (2 = 32 bits) |
| cmd_postexec | input | 1 | Jump to the program buffer after the transfer |
| csr_access_en | input | 1 | Allow CSR access through commands |
| err_in | input | 3 | Current command error state |
| buf_we | output | 1 | Buffer word write strobe |
| buf_idx | output | 4 | Buffer word index |
| buf_data | output | 32 | Instruction word |
| done | output | 1 | Command finished (one-cycle pulse) |
| err_set | output | 1 | Report `err_code` into the error state |
| err_code | output | 3 | Error code (2 = not supported) |

## Verification
A wrong sequencer phase or step count shows up at the ports as a missing, duplicated or reordered word. It also breaks the index run, or puts `done` early or late. Any of these appears within the eleven cycles of the longest burst. A mis-held register class or write flag gives the wrong opcode or CSR field in the access word, which is visible in the very cycle it is written. A stale error flag gives a spurious `err_set` on the next clean command. A wrong index register shows up in the next post-execute jump offset.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRO, PH_SAVE, PH_ACC, PH_REST, PH_EPI, PH_TERM, PH_FIN
  } phase_t;

  typedef enum logic [1:0] {RK_CSR, RK_GPR, RK_FPR, RK_BAD} reg_kind_t;

  localparam logic [4:0]  RS0      = 5'd8;
  localparam logic [11:0] CSR_DS0  = 12'h7B2;
  localparam logic [11:0] CSR_DS1  = 12'h7B3;
  localparam logic [11:0] CSR_MST  = 12'h300;
  localparam logic [31:0] W_EBREAK = 32'h0010_0073;
  localparam logic [2:0]  ERR_NOTSUP = 3'd2;

  // csrrw x0, csr, rs
  function automatic logic [31:0] f_csrw(input logic [11:0] csr, input logic [4:0] rs);
    return {csr, rs, 3'b001, 5'd0, 7'h73};
  endfunction

  // csrrs rd, csr, x0
  function automatic logic [31:0] f_csrr(input logic [4:0] rd, input logic [11:0] csr);
    return {csr, 5'd0, 3'b010, rd, 7'h73};
  endfunction

  // csrrs x0, csr, rs
  function automatic logic [31:0] f_csrset(input logic [11:0] csr, input logic [4:0] rs);
    return {csr, rs, 3'b010, 5'd0, 7'h73};
  endfunction

  function automatic logic [31:0] f_lui(input logic [4:0] rd, input logic [19:0] imm);
    return {imm, rd, 7'h37};
  endfunction

  // fmv.x.w rd, fs
  function automatic logic [31:0] f_fmv_xw(input logic [4:0] rd, input logic [4:0] fs);
    return {7'h70, 5'd0, fs, 3'b000, rd, 7'h53};
  endfunction

  // fmv.w.x fd, rs
  function automatic logic [31:0] f_fmv_wx(input logic [4:0] fd, input logic [4:0] rs);
    return {7'h78, 5'd0, rs, 3'b000, fd, 7'h53};
  endfunction

  // jal x0, off
  function automatic logic [31:0] f_jal0(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
  endfunction

endpackage

// File: rtl/abs_seq_decode.sv
module abs_seq_decode
  import abs_seq_pkg::*;
#(
  parameter int REGW  = 16,
  parameter int SIZEW = 3
) (
  input  logic [REGW-1:0]  regno,
  input  logic [SIZEW-1:0] size,
  input  logic             csr_en,
  output reg_kind_t        kind,
  output logic             is_fpu,
  output logic             supported
);
  localparam logic [REGW-1:0] GPR_LO = REGW'('h1000);
  localparam logic [REGW-1:0] FPR_LO = REGW'('h1020);
  localparam logic [REGW-1:0] FPR_HI = REGW'('h103F);

  logic in_fpr;
  logic size_ok;

  assign in_fpr  = (regno >= FPR_LO) && (regno <= FPR_HI);
  assign size_ok = (size == SIZEW'(2));
  assign is_fpu  = in_fpr || (regno == REGW'(1)) || (regno == REGW'(2)) ||
                   (regno == REGW'(3));

  always_comb begin
    if (regno < GPR_LO)      kind = RK_CSR;
    else if (regno < FPR_LO) kind = RK_GPR;
    else if (in_fpr)         kind = RK_FPR;
    else                     kind = RK_BAD;
  end

  always_comb begin
    unique case (kind)
      RK_CSR:  supported = size_ok && csr_en;
      RK_GPR:  supported = size_ok;
      RK_FPR:  supported = size_ok;
      default: supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/abs_seq_emit.sv
module abs_seq_emit
  import abs_seq_pkg::*;
#(
  parameter int          IDXW     = 4,
  parameter int          PBUF_GAP = 64,
  parameter logic [11:0] XFER_CSR = 12'h7C0,
  parameter logic [19:0] FS_HI    = 20'h00006
) (
  input  phase_t          phase,
  input  logic [2:0]      step,
  input  reg_kind_t       kind,
  input  logic            write,
  input  logic            postexec,
  input  logic [11:0]     regno,
  input  logic [IDXW-1:0] idx,
  output logic [31:0]     word
);
  logic [4:0]  rn;
  logic [20:0] jofs;

  // Integer and FP data registers: low five bits give the register index.
  assign rn   = regno[4:0];
  assign jofs = 21'(PBUF_GAP) - (21'(idx) << 2);

  always_comb begin
    word = '0;
    unique case (phase)
      PH_PRO: begin
        unique case (step)
          3'd0:    word = f_csrw(CSR_DS0, RS0);
          3'd1:    word = f_csrr(RS0, CSR_MST);
          3'd2:    word = f_csrw(CSR_DS1, RS0);
          3'd3:    word = f_lui(RS0, FS_HI);
          default: word = f_csrset(CSR_MST, RS0);
        endcase
      end
      PH_SAVE: word = f_csrw(CSR_DS0, RS0);
      PH_REST: word = f_csrr(RS0, CSR_DS0);
      PH_EPI: begin
        unique case (step)
          3'd0:    word = f_csrr(RS0, CSR_DS1);
          3'd1:    word = f_csrw(CSR_MST, RS0);
          default: word = f_csrr(RS0, CSR_DS0);
        endcase
      end
      PH_ACC: begin
        unique case (kind)
          RK_GPR:  word = write ? f_csrr(rn, XFER_CSR) : f_csrw(XFER_CSR, rn);
          RK_FPR: begin
            if (step == 3'd0) word = write ? f_csrr(RS0, XFER_CSR) : f_fmv_xw(RS0, rn);
            else              word = write ? f_fmv_wx(rn, RS0)     : f_csrw(XFER_CSR, RS0);
          end
          default: begin
            if (step == 3'd0) word = write ? f_csrr(RS0, XFER_CSR) : f_csrr(RS0, regno);
            else              word = write ? f_csrw(regno, RS0)    : f_csrw(XFER_CSR, RS0);
          end
        endcase
      end
      PH_TERM: word = postexec ? f_jal0(jofs) : W_EBREAK;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/abs_reg_seq.sv
module abs_reg_seq
  import abs_seq_pkg::*;
#(
  parameter int          BUF_DEPTH = 16,
  parameter int          REGW      = 16,
  parameter int          SIZEW     = 3,
  parameter int          ERRW      = 3,
  parameter int          PBUF_GAP  = 4 * BUF_DEPTH,
  parameter logic [11:0] XFER_CSR  = 12'h7C0,
  parameter logic [19:0] FS_HI     = 20'h00006,
  localparam int         IDXW      = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [REGW-1:0]  cmd_regno,
  input  logic             cmd_transfer,
  input  logic             cmd_write,
  input  logic [SIZEW-1:0] cmd_size,
  input  logic             cmd_postexec,
  input  logic             csr_access_en,
  input  logic [ERRW-1:0]  err_in,
  output logic             buf_we,
  output logic [IDXW-1:0]  buf_idx,
  output logic [31:0]      buf_data,
  output logic             done,
  output logic             err_set,
  output logic [ERRW-1:0]  err_code
);
  localparam logic [2:0] PRO_LAST = 3'd4;
  localparam logic [2:0] EPI_LAST = 3'd2;

  phase_t          phase;
  logic [2:0]      step;
  reg_kind_t       kind_q;
  logic            fpu_q, write_q, pexec_q, err_q;
  logic [11:0]     regno_q;
  logic [IDXW-1:0] idx;

  reg_kind_t d_kind;
  logic      d_fpu, d_ok, accept, acc_last;

  abs_seq_decode #(.REGW(REGW), .SIZEW(SIZEW)) u_dec (
    .regno(cmd_regno), .size(cmd_size), .csr_en(csr_access_en),
    .kind(d_kind), .is_fpu(d_fpu), .supported(d_ok)
  );

  abs_seq_emit #(.IDXW(IDXW), .PBUF_GAP(PBUF_GAP), .XFER_CSR(XFER_CSR), .FS_HI(FS_HI)) u_emit (
    .phase(phase), .step(step), .kind(kind_q), .write(write_q),
    .postexec(pexec_q), .regno(regno_q), .idx(idx), .word(buf_data)
  );

  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign acc_last  = (kind_q == RK_GPR) || (step == 3'd1);
  assign buf_we    = (phase != PH_IDLE) && (phase != PH_FIN);
  assign buf_idx   = idx;
  assign done      = (phase == PH_FIN);
  assign err_set   = done && err_q;
  assign err_code  = err_set ? ERRW'(ERR_NOTSUP) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      step    <= '0;
      idx     <= '0;
      kind_q  <= RK_CSR;
      fpu_q   <= 1'b0;
      write_q <= 1'b0;
      pexec_q <= 1'b0;
      err_q   <= 1'b0;
      regno_q <= '0;
    end else begin
      if (buf_we) idx <= idx + 1'b1;
      unique case (phase)
        PH_IDLE: if (accept) begin
          idx     <= '0;
          step    <= '0;
          kind_q  <= d_kind;
          fpu_q   <= d_fpu;
          write_q <= cmd_write;
          pexec_q <= cmd_postexec;
          regno_q <= cmd_regno[11:0];
          err_q   <= 1'b0;
          if (err_in != '0)              phase <= PH_FIN;
          else if (!cmd_transfer)        phase <= PH_TERM;
          else if (!d_ok) begin          phase <= PH_FIN; err_q <= 1'b1; end
          else if (d_fpu)                phase <= PH_PRO;
          else if (d_kind == RK_CSR)     phase <= PH_SAVE;
          else                           phase <= PH_ACC;
        end
        PH_PRO: begin
          step <= (step == PRO_LAST) ? 3'd0 : step + 3'd1;
          if (step == PRO_LAST) phase <= PH_ACC;
        end
        PH_SAVE: phase <= PH_ACC;
        PH_ACC: begin
          step <= acc_last ? 3'd0 : step + 3'd1;
          if (acc_last) phase <= fpu_q ? PH_EPI : ((kind_q == RK_CSR) ? PH_REST : PH_TERM);
        end
        PH_REST: phase <= PH_TERM;
        PH_EPI: begin
          step <= (step == EPI_LAST) ? 3'd0 : step + 3'd1;
          if (step == EPI_LAST) phase <= PH_TERM;
        end
        PH_TERM: phase <= PH_FIN;
        default: begin
          phase <= PH_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/abs_reg_seq_chk.sv
module abs_reg_seq_chk #(
  parameter int IDXW = 4,
  parameter int ERRW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [ERRW-1:0] err_in,
  input logic            buf_we,
  input logic [IDXW-1:0] buf_idx,
  input logic            done,
  input logic            err_set
);
  // R1: no word is written while a new command could be taken
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !cmd_ready);

  // R2: a burst starts at index 0
  p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_we) |-> (buf_idx == '0));

  // R2: consecutive writes step the index by one
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && $past(buf_we)) |-> (buf_idx == $past(buf_idx) + 1'b1));

  // R2: done never overlaps a write
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !buf_we);

  // R3: an existing error suppresses all writes and reporting
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (err_in != '0)) |=> (done && !buf_we && !err_set));

  // R10: an error report comes with done and follows no write
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> (done && !$past(buf_we)));
endmodule

bind abs_reg_seq abs_reg_seq_chk #(.IDXW(IDXW), .ERRW(ERRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .err_in(err_in), .buf_we(buf_we), .buf_idx(buf_idx), .done(done),
  .err_set(err_set)
);

// File: tb/abs_reg_seq_tb.sv
module abs_reg_seq_tb;
  localparam logic [31:0] EBRK = 32'h0010_0073;
  localparam int GAP = 64;
  localparam logic [11:0] DS0 = 12'h7B2, DS1 = 12'h7B3, MST = 12'h300, XF = 12'h7C0;
  localparam logic [4:0] S0 = 5'd8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_regno = '0;
  logic cmd_transfer = 1'b0, cmd_write = 1'b0, cmd_postexec = 1'b0, csr_access_en = 1'b0;
  logic [2:0] cmd_size = 3'd2, err_in = '0;
  logic buf_we, done, err_set;
  logic [3:0] buf_idx;
  logic [31:0] buf_data;
  logic [2:0] err_code;

  int checks = 0, errors = 0;
  logic [31:0] exp_w [16];
  logic [31:0] got_w [16];
  int exp_n, got_n;
  logic got_err;
  logic [2:0] got_code;

  always #4 clk = ~clk;

  abs_reg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_regno(cmd_regno), .cmd_transfer(cmd_transfer), .cmd_write(cmd_write),
    .cmd_size(cmd_size), .cmd_postexec(cmd_postexec), .csr_access_en(csr_access_en),
    .err_in(err_in), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .done(done), .err_set(err_set), .err_code(err_code)
  );

  function automatic logic [31:0] e_csrw(input logic [11:0] c, input logic [4:0] rs);
    return (32'(c) << 20) | (32'(rs) << 15) | 32'h1073;
  endfunction
  function automatic logic [31:0] e_csrr(input logic [4:0] rd, input logic [11:0] c);
    return (32'(c) << 20) | (32'(rd) << 7) | 32'h2073;
  endfunction
  function automatic logic [31:0] e_csrs(input logic [11:0] c, input logic [4:0] rs);
    return (32'(c) << 20) | (32'(rs) << 15) | 32'h2073;
  endfunction
  function automatic logic [31:0] e_jal(input int off);
    logic [20:0] i;
    i = off[20:0];
    return {i[20], i[10:1], i[11], i[19:12], 12'h06F};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] w);
    exp_w[exp_n] = w;
    exp_n++;
  endtask

  task automatic push_pro();
    push(e_csrw(DS0, S0)); push(e_csrr(S0, MST)); push(e_csrw(DS1, S0));
    push({20'h00006, S0, 7'h37}); push(e_csrs(MST, S0));
  endtask

  task automatic push_epi();
    push(e_csrr(S0, DS1)); push(e_csrw(MST, S0)); push(e_csrr(S0, DS0));
  endtask

  task automatic run_cmd(input logic [15:0] rg, input logic xf, input logic wr,
                         input logic [2:0] sz, input logic pe, input logic ce,
                         input logic [2:0] ei, input string req);
    bit fin;
    @(negedge clk);
    cmd_regno = rg; cmd_transfer = xf; cmd_write = wr; cmd_size = sz;
    cmd_postexec = pe; csr_access_en = ce; err_in = ei; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R1", "ready before command", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    got_n = 0; fin = 1'b0; got_err = 1'b0; got_code = '0;
    for (int c = 0; c < 30 && !fin; c++) begin
      if (c > 0) @(negedge clk);
      if (cmd_ready) chk(1'b0, "R1", "ready while busy", 32'd1, 32'd0);
      if (buf_we) begin
        if (buf_idx != 4'(got_n))
          chk(1'b0, req, "buffer index", 32'(buf_idx), 32'(got_n));
        if (got_n < 16) got_w[got_n] = buf_data;
        got_n++;
      end
      if (done) begin
        fin = 1'b1; got_err = err_set; got_code = err_code;
        if (buf_we) chk(1'b0, "R2", "write with done", 32'd1, 32'd0);
      end
    end
    chk(fin, "R2", "done seen", 32'(fin), 32'd1);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after done", 32'(cmd_ready), 32'd1);
  endtask

  task automatic expect_seq(input string req, input logic ee);
    chk(got_n == exp_n, req, "word count", 32'(got_n), 32'(exp_n));
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_w[k] == exp_w[k], req, $sformatf("word %0d", k), got_w[k], exp_w[k]);
    chk(got_err == ee, req, "err_set", 32'(got_err), 32'(ee));
    chk(got_code == (ee ? 3'd2 : 3'd0), req, "err_code", 32'(got_code), ee ? 32'd2 : 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "reset ready", 32'(cmd_ready), 32'd1);
    chk(buf_we == 1'b0 && done == 1'b0 && err_set == 1'b0, "R2", "reset outputs quiet",
        {29'd0, buf_we, done, err_set}, 32'd0);
  endtask

  task automatic t_csr_rw();
    // R6 R9: CSR read of 0x305 bracketed by s0 save/restore
    run_cmd(16'h0305, 1, 0, 3'd2, 0, 1, 3'd0, "R9");
    exp_n = 0;
    push(e_csrw(DS0, S0)); push(e_csrr(S0, 12'h305)); push(e_csrw(XF, S0));
    push(e_csrr(S0, DS0)); push(EBRK);
    expect_seq("R6", 1'b0);
    // R9: CSR write of 0x340 with postexec, terminator at index 4 (R11)
    run_cmd(16'h0340, 1, 1, 3'd2, 1, 1, 3'd0, "R9");
    exp_n = 0;
    push(e_csrw(DS0, S0)); push(e_csrr(S0, XF)); push(e_csrw(12'h340, S0));
    push(e_csrr(S0, DS0)); push(e_jal(GAP - 16));
    expect_seq("R9", 1'b0);
  endtask

  task automatic t_gpr();
    // R7: read x5 from regno 0x1005
    run_cmd(16'h1005, 1, 0, 3'd2, 0, 0, 3'd0, "R7");
    exp_n = 0; push(e_csrw(XF, 5'd5)); push(EBRK);
    expect_seq("R7", 1'b0);
    // R7 R11: write x10 with postexec, jump from index 1
    run_cmd(16'h100A, 1, 1, 3'd2, 1, 0, 3'd0, "R7");
    exp_n = 0; push(e_csrr(5'd10, XF)); push(e_jal(GAP - 4));
    expect_seq("R11", 1'b0);
  endtask

  task automatic t_fpr();
    // R4 R5 R8: read f3 with wrapper
    run_cmd(16'h1023, 1, 0, 3'd2, 0, 0, 3'd0, "R8");
    exp_n = 0; push_pro();
    push({7'h70, 5'd0, 5'd3, 3'b000, S0, 7'h53}); push(e_csrw(XF, S0));
    push_epi(); push(EBRK);
    expect_seq("R4", 1'b0);
    // R8 R5: write f31
    run_cmd(16'h103F, 1, 1, 3'd2, 0, 0, 3'd0, "R8");
    exp_n = 0; push_pro();
    push(e_csrr(S0, XF)); push({7'h78, 5'd0, S0, 3'b000, 5'd31, 7'h53});
    push_epi(); push(EBRK);
    expect_seq("R5", 1'b0);
  endtask

  task automatic t_fcsr();
    // R6: an FP CSR gets only the wrapper, no extra s0 bracket
    run_cmd(16'h0003, 1, 1, 3'd2, 0, 1, 3'd0, "R6");
    exp_n = 0; push_pro();
    push(e_csrr(S0, XF)); push(e_csrw(12'h003, S0));
    push_epi(); push(EBRK);
    expect_seq("R6", 1'b0);
  endtask

  task automatic t_notsup();
    exp_n = 0;
    run_cmd(16'h0305, 1, 0, 3'd2, 0, 0, 3'd0, "R10");
    expect_seq("R10", 1'b1);
    run_cmd(16'h0002, 1, 0, 3'd2, 0, 0, 3'd0, "R10");
    expect_seq("R10", 1'b1);
    run_cmd(16'h1005, 1, 0, 3'd3, 0, 1, 3'd0, "R10");
    expect_seq("R10", 1'b1);
    run_cmd(16'h1040, 1, 0, 3'd2, 1, 1, 3'd0, "R10");
    expect_seq("R10", 1'b1);
  endtask

  task automatic t_err_in();
    // R3: pre-existing error, supported and unsupported commands alike
    exp_n = 0;
    run_cmd(16'h1023, 1, 0, 3'd2, 1, 1, 3'd1, "R3");
    expect_seq("R3", 1'b0);
    run_cmd(16'h1040, 1, 0, 3'd2, 0, 0, 3'd4, "R3");
    expect_seq("R3", 1'b0);
  endtask

  task automatic t_no_xfer();
    // R12: only the terminator; regno and size ignored
    run_cmd(16'h1040, 0, 1, 3'd7, 1, 0, 3'd0, "R12");
    exp_n = 0; push(e_jal(GAP));
    expect_seq("R12", 1'b0);
    run_cmd(16'h0305, 0, 0, 3'd2, 0, 0, 3'd0, "R12");
    exp_n = 0; push(EBRK);
    expect_seq("R12", 1'b0);
  endtask

  task automatic t_backpressure();
    // R1: valid held across a busy sequencer is taken only once it is idle again
    @(negedge clk);
    cmd_regno = 16'h1001; cmd_transfer = 1; cmd_write = 0; cmd_size = 3'd2;
    cmd_postexec = 0; csr_access_en = 0; err_in = '0; cmd_valid = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1", "busy after accept", 32'(cmd_ready), 32'd0);
    @(negedge clk); @(negedge clk);
    chk(done == 1'b1, "R2", "done after two words", 32'(done), 32'd1);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready for held command", 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(buf_we == 1'b1 && buf_idx == 4'd0, "R1", "held command starts",
        {27'd0, buf_we, buf_idx}, 32'h10);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr_rw();
    t_gpr();
    t_fpr();
    t_fcsr();
    t_notsup();
    t_err_in();
    t_no_xfer();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule